// File: doc/BRIEF.md
# Serial GPIO Shift Master

This block turns four chip pins into a long row of general-purpose inputs and outputs. An external chain of shift registers sits on the other side of the pins. Each position in the chain carries one output line and one input line. A programmable divider derives a serial clock from the bus clock. While the block is enabled, it runs frames back to back. Each frame opens with a one-cycle active-low load strobe. It then clocks the chain once for every position, driving one latched output bit and sampling one input bit per serial clock period.

Software uses a small word-addressed register bus with plain read and write strobes. Bank `b` (32 positions) has a value register at word address `2*b` and a readback register at word address `2*b+1`. Writing a value register sets that bank's output latches. Reading it returns the captured inputs. The readback register returns the output latches. A control register at the all-ones word address holds the divider, the chain length in units of eight positions, and the enable. Position `p` maps to bank `p/32`, bit `p%32`, and position 0 is shifted first.

Top module: `sgm_master`

## Requirements
- R1: After reset, `sg_clk` and `sg_load` are high, `sg_dout` is 0, and the control, value and readback registers all read 0.
- R2: The control register keeps the divider in bits 31:16, the length field (positions/8) in bits 10:6 and the enable in bit 0. A read returns exactly those fields, and every other bit reads 0.
- R3: A frame starts with `sg_load` low for exactly one bus cycle, and `sg_clk` is high during that cycle.
- R4: A frame has exactly `min(length*8, 32*NUM_BANKS)` serial clock periods. With a length field of 0, no frame starts.
- R5: Each serial clock period is 2*(divider+1) bus cycles: first divider+1 cycles low, then divider+1 cycles high.
- R6: During period `p` of a frame, `sg_dout` carries output latch bit `p%32` of bank `p/32`. It is valid from the falling edge of `sg_clk` until the next period.
- R7: `sg_din` is sampled where `sg_clk` rises in period `p` and lands in bit `p%32` of bank `p/32` of the captured inputs. Positions beyond the chain length read 0.
- R8: The captured inputs change all together, only after the last period of a completed frame. A read during a frame returns the previous frame's data.
- R9: A write to a value register sets that bank's output latches, and the readback register returns them. A write to a readback address has no effect.
- R10: While the enable is 0, `sg_clk` and `sg_load` stay high. Clearing the enable in the middle of a frame stops it at once and leaves the captured inputs unchanged.
- R11: While enabled, the next load strobe comes right after the last high phase, so frames are spaced exactly 1 + N*2*(divider+1) bus cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sg_clk | output | 1 | Serial clock to the chain, idle high |
| sg_load | output | 1 | Active-low frame load strobe, idle high |
| sg_dout | output | 1 | Serial output data |
| sg_din | input | 1 | Serial input data from the chain |

## Verification
The hardest cases to reach are the ones that depend on timing inside a frame. One is a read landing in the middle of a frame after the incoming pattern has changed, which must still return the old frame's data. Another is clearing the enable partway through the chain. The bench models the shift chain around the pins, so it knows which position is being shifted at any moment. It changes its input pattern or drops the enable only once it has counted a chosen number of serial clock rises. It then waits for a set number of later load strobes before it expects the new data.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  localparam int BANK_BITS    = 32;
  localparam int DIV_W        = 16;
  localparam int CNT_W        = 5;
  localparam int CTRL_DIV_LSB = 16;
  localparam int CTRL_CNT_LSB = 6;
  localparam int CTRL_EN_BIT  = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } sgm_state_e;
endpackage

// File: rtl/sgm_clkdiv.sv
module sgm_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);

  // R5: half-period counter never passes the latched divider
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div));
endmodule

// File: rtl/sgm_frame.sv
module sgm_frame import sgm_pkg::*; #(
  parameter int NUM_BANKS = 2,
  localparam int POS   = NUM_BANKS * BANK_BITS,
  localparam int POS_W = $clog2(POS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [DIV_W-1:0] div,
  input  logic [POS-1:0]   out_lat,
  input  logic             din,
  output logic             sclk,
  output logic             load,
  output logic             dout,
  output logic [POS-1:0]   cap_data,
  output logic             cap_stb
);
  localparam logic [CNT_W+3:0] POS_V = (CNT_W+4)'(POS);

  sgm_state_e       st;
  logic [POS_W-1:0] pos, pos_nx, last_l, last_n;
  logic [DIV_W-1:0] div_l;
  logic [POS-1:0]   shreg;
  logic [CNT_W+3:0] npos_raw, npos_c;
  logic             tick;

  always_comb begin
    npos_raw = {1'b0, cnt, 3'b000};
    npos_c   = (npos_raw > POS_V) ? POS_V : npos_raw;
    last_n   = POS_W'(npos_c - 1'b1);
    pos_nx   = pos + 1'b1;
  end

  sgm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st == ST_SHIFT),
    .div  (div_l),
    .tick (tick)
  );

  assign cap_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sclk    <= 1'b1;
      load    <= 1'b1;
      dout    <= 1'b0;
      pos     <= '0;
      last_l  <= '0;
      div_l   <= '0;
      shreg   <= '0;
      cap_stb <= 1'b0;
    end else begin
      cap_stb <= 1'b0;
      case (st)
        ST_IDLE: begin
          sclk <= 1'b1;
          load <= 1'b1;
          dout <= 1'b0;
          if (en && (cnt != '0)) begin
            st     <= ST_LOAD;
            load   <= 1'b0;
            last_l <= last_n;
            div_l  <= div;
          end
        end
        ST_LOAD: begin
          load <= 1'b1;
          if (!en) begin
            st <= ST_IDLE;
          end else begin
            st    <= ST_SHIFT;
            sclk  <= 1'b0;
            pos   <= '0;
            dout  <= out_lat[0];
            shreg <= '0;
          end
        end
        ST_SHIFT: begin
          if (!en) begin
            st   <= ST_IDLE;
            sclk <= 1'b1;
            load <= 1'b1;
            dout <= 1'b0;
          end else if (tick) begin
            if (!sclk) begin
              sclk       <= 1'b1;
              shreg[pos] <= din;
            end else if (pos == last_l) begin
              cap_stb <= 1'b1;
              if (cnt != '0) begin
                st     <= ST_LOAD;
                load   <= 1'b0;
                last_l <= last_n;
                div_l  <= div;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              pos  <= pos_nx;
              sclk <= 1'b0;
              dout <= out_lat[pos_nx];
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: load strobe lasts a single cycle
  assert_load_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> load);
  // R3: serial clock is high while load is asserted
  assert_load_clk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> sclk);
  // R4: shift position stays inside the latched chain length
  assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT) |-> (pos <= last_l));
  // R10: disabled block keeps both strobes idle-high
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk && load));
endmodule

// File: rtl/sgm_regs.sv
module sgm_regs import sgm_pkg::*; #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 6,
  localparam int POS = NUM_BANKS * BANK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ctrl_en,
  output logic [CNT_W-1:0]  ctrl_cnt,
  output logic [DIV_W-1:0]  ctrl_div,
  output logic [POS-1:0]    out_lat,
  input  logic [POS-1:0]    cap_data,
  input  logic              cap_stb
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

  logic [POS-1:0] in_reg;
  logic [31:0]    rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_cnt <= '0;
      ctrl_div <= '0;
    end else if (bus_wr && bus_addr == CTRL_ADDR) begin
      ctrl_en  <= bus_wdata[CTRL_EN_BIT];
      ctrl_cnt <= bus_wdata[CTRL_CNT_LSB +: CNT_W];
      ctrl_div <= bus_wdata[CTRL_DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lat <= '0;
    end else if (bus_wr) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr == ADDR_W'(2 * b)) out_lat[b*BANK_BITS +: BANK_BITS] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_reg <= '0;
    else if (cap_stb) in_reg <= cap_data;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == CTRL_ADDR) begin
      rd_mux[CTRL_DIV_LSB +: DIV_W] = ctrl_div;
      rd_mux[CTRL_CNT_LSB +: CNT_W] = ctrl_cnt;
      rd_mux[CTRL_EN_BIT]           = ctrl_en;
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(2 * b))     rd_mux = in_reg[b*BANK_BITS +: BANK_BITS];
      if (bus_addr == ADDR_W'(2 * b + 1)) rd_mux = out_lat[b*BANK_BITS +: BANK_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_chk
    // R9: writing a readback address leaves the latches alone
    assert_ro_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(2 * g + 1)) |=> $stable(out_lat[g*BANK_BITS +: BANK_BITS]));
  end

  // R8: captured inputs change only on a completed-frame strobe
  assert_capture_atomic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(in_reg));
endmodule

// File: rtl/sgm_master.sv
module sgm_master import sgm_pkg::*; #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sg_clk,
  output logic              sg_load,
  output logic              sg_dout,
  input  logic              sg_din
);
  localparam int POS = NUM_BANKS * BANK_BITS;

  logic             ctrl_en, cap_stb;
  logic [CNT_W-1:0] ctrl_cnt;
  logic [DIV_W-1:0] ctrl_div;
  logic [POS-1:0]   out_lat, cap_data;

  sgm_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ctrl_en  (ctrl_en),
    .ctrl_cnt (ctrl_cnt),
    .ctrl_div (ctrl_div),
    .out_lat  (out_lat),
    .cap_data (cap_data),
    .cap_stb  (cap_stb)
  );

  sgm_frame #(.NUM_BANKS(NUM_BANKS)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_en),
    .cnt     (ctrl_cnt),
    .div     (ctrl_div),
    .out_lat (out_lat),
    .din     (sg_din),
    .sclk    (sg_clk),
    .load    (sg_load),
    .dout    (sg_dout),
    .cap_data(cap_data),
    .cap_stb (cap_stb)
  );
endmodule

// File: tb/sgm_master_test.sv
module sgm_master_test;
  localparam int NB = 2;
  localparam int AW = 6;
  localparam int NP = NB * 32;
  localparam logic [AW-1:0] CTRL_A = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sg_clk, sg_load, sg_dout, sg_din;

  always #10 clk = ~clk;

  int errors = 0, checks = 0;

  // chain model and monitor state
  logic [NP-1:0] in_pat = '0, out_seen = '0;
  int  bpos = 0, rises = 0, loads = 0, low_len = 0, high_len = 0, gap = 0;
  int  rise_bad = 0, per_bad = 0, gap_bad = 0, ld_bad = 0;
  bit  en_sh = 0, in_frame = 0, after_load = 0;
  logic prev_clk = 1'b1, prev_load = 1'b1;
  int  cur_n = 0, cur_div = 0;

  assign sg_din = in_pat[bpos % NP];

  sgm_master #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sg_clk(sg_clk), .sg_load(sg_load),
    .sg_dout(sg_dout), .sg_din(sg_din));

  always @(negedge clk) begin
    if (!en_sh) in_frame = 0;
    gap++;
    if (!sg_load) begin
      if (!prev_load) ld_bad++;                    // R3 width
      if (!sg_clk) ld_bad++;                       // R3 clock high
      if (in_frame) begin
        if (rises != cur_n) rise_bad++;            // R4
        if (gap != 1 + cur_n * 2 * (cur_div + 1)) gap_bad++;  // R11
      end
      loads++; rises = 0; bpos = 0; gap = 0;
      in_frame = en_sh; after_load = 1;
    end
    if (sg_clk && !prev_clk) begin
      if (in_frame && low_len != cur_div + 1) per_bad++;     // R5
      out_seen[bpos % NP] = sg_dout;
      bpos++; rises++; low_len = 0; high_len = 1;
    end else if (!sg_clk && prev_clk) begin
      if (in_frame && !after_load && high_len != cur_div + 1) per_bad++;  // R5
      after_load = 0; high_len = 0; low_len = 1;
    end else if (sg_clk) high_len++;
    else low_len++;
    prev_clk = sg_clk; prev_load = sg_load;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input int div, input int cnt, input bit en);
    logic [31:0] w = '0;
    w[31:16] = 16'(div); w[10:6] = 5'(cnt); w[0] = en;
    return w;
  endfunction

  function automatic int exp_n(input int cnt);
    return (cnt * 8 > NP) ? NP : cnt * 8;
  endfunction

  function automatic logic [31:0] exp_val(input logic [NP-1:0] pat, input int n, input int b);
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++) if (b * 32 + i < n) v[i] = pat[b * 32 + i];
    return v;
  endfunction

  task automatic run_case(input int cnt, input int div, input logic [NP-1:0] outs, input logic [NP-1:0] ins);
    logic [31:0] d;
    int n = exp_n(cnt);
    wr(0, outs[31:0]); wr(2, outs[63:32]);
    in_pat = ins; cur_n = n; cur_div = div;
    rise_bad = 0; per_bad = 0; gap_bad = 0; ld_bad = 0;
    en_sh = 1;
    wr(CTRL_A, ctrl_word(div, cnt, 1'b1));
    begin
      int t = loads + 3;
      wait (loads >= t);
    end
    @(negedge clk); @(negedge clk);
    en_sh = 0;
    wr(CTRL_A, ctrl_word(div, cnt, 1'b0));
    chk(rise_bad == 0, "R4 periods per frame", 64'(rise_bad), 0);
    chk(per_bad == 0, "R5 half-period lengths", 64'(per_bad), 0);
    chk(gap_bad == 0, "R11 frame spacing", 64'(gap_bad), 0);
    chk(ld_bad == 0, "R3 load strobe", 64'(ld_bad), 0);
    for (int p = 0; p < n; p++)
      if (out_seen[p] !== outs[p]) begin
        chk(0, "R6 serial output bit", 64'(p), 64'(outs[p]));
        break;
      end
    chk(1, "R6 serial output", 0, 0);
    for (int b = 0; b < NB; b++) begin
      rd(AW'(2 * b), d);
      chk(d === exp_val(ins, n, b), "R7 captured inputs", 64'(d), 64'(exp_val(ins, n, b)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d, a, b0;
    logic [NP-1:0] pa, pb;
    int l0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(sg_clk === 1'b1 && sg_load === 1'b1 && sg_dout === 1'b0, "R1 pins after reset",
        64'({sg_clk, sg_load, sg_dout}), 64'(3'b110));
    rd(CTRL_A, d); chk(d === 0, "R1 control after reset", 64'(d), 0);
    rd(0, d);      chk(d === 0, "R1 value after reset", 64'(d), 0);
    rd(1, d);      chk(d === 0, "R1 readback after reset", 64'(d), 0);
    // R2 control layout
    wr(CTRL_A, 32'hABCD_FFFE);
    rd(CTRL_A, d); chk(d === 32'hABCD_07C0, "R2 control fields", 64'(d), 64'h ABCD07C0);
    // R10 disabled: no frames
    l0 = loads;
    repeat (100) @(negedge clk);
    chk(loads == l0 && sg_clk && sg_load, "R10 no frames when disabled", 64'(loads - l0), 0);
    wr(CTRL_A, 0);
    // R9 latches and readback
    a = $urandom; b0 = $urandom;
    wr(0, a); wr(2, b0);
    rd(1, d); chk(d === a, "R9 readback bank0", 64'(d), 64'(a));
    rd(3, d); chk(d === b0, "R9 readback bank1", 64'(d), 64'(b0));
    wr(1, ~a);
    rd(1, d); chk(d === a, "R9 readback write ignored", 64'(d), 64'(a));
    rd(0, d); chk(d === 0, "R9 value unaffected by latch write", 64'(d), 0);
    // directed corners and random frames
    run_case(8, 0, {$urandom, $urandom}, {$urandom, $urandom});
    run_case(1, 3, {$urandom, $urandom}, {$urandom, $urandom});
    run_case(31, 1, {$urandom, $urandom}, {$urandom, $urandom});   // R4 clamp to 64
    for (int i = 0; i < 6; i++)
      run_case(1 + int'($urandom % 8), int'($urandom % 5), {$urandom, $urandom}, {$urandom, $urandom});
    // R8 mid-frame read returns previous frame
    pa = {$urandom, $urandom}; pb = ~pa;
    in_pat = pa; cur_n = 64; cur_div = 2;
    en_sh = 1;
    wr(CTRL_A, ctrl_word(2, 8, 1'b1));
    l0 = loads; wait (loads >= l0 + 2);
    wait (rises >= 20);
    in_pat = pb;
    rd(0, d); chk(d === pa[31:0], "R8 mid-frame read keeps old frame", 64'(d), 64'(pa[31:0]));
    l0 = loads; wait (loads >= l0 + 2);
    @(negedge clk); @(negedge clk);
    rd(2, d); chk(d === pb[63:32], "R8 new frame after completion", 64'(d), 64'(pb[63:32]));
    // R10 abort mid-frame
    wait (rises >= 30);
    en_sh = 0;
    in_pat = pa;
    wr(CTRL_A, ctrl_word(2, 8, 1'b0));
    l0 = loads;
    begin
      int bad = 0;
      repeat (60) begin @(negedge clk); if (!sg_clk || !sg_load) bad++; end
      chk(bad == 0 && loads == l0, "R10 idle after abort", 64'(bad), 0);
    end
    rd(0, d); chk(d === pb[31:0], "R10 capture unchanged by abort", 64'(d), 64'(pb[31:0]));
    // R4 zero length: no frame even when enabled
    wr(CTRL_A, ctrl_word(0, 0, 1'b1));
    l0 = loads;
    repeat (200) @(negedge clk);
    chk(loads == l0, "R4 zero length starts no frame", 64'(loads - l0), 0);
    wr(CTRL_A, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule